// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the video timing for a parallel RGB panel. It runs on the pixel clock. Software writes total, sync-width, wait and active counts for both axes through a simple register write port. The block then produces horizontal and vertical sync, a data-enable, a pixel-valid strobe for the fetch side, and a frame-done interrupt. The line and frame both start at the leading edge of their sync pulse. The active window opens a programmed number of clocks (or lines) after that edge.

Software controls the polarity of each sync and enable output, a dot-clock edge select that it passes to the panel, a run bit and a sync-enable bit. The block holds two framebuffer base addresses. The pending address is promoted to the current one at every frame boundary, and the current address can also be written directly before starting. Timing counts are shadowed so that a write made during a frame takes effect only at the next frame. When the run bit is cleared, the block keeps scanning until the pixel FIFO reports empty. A FIFO underflow can be recovered at the start of the next frame: the block suppresses pixel-valid for the rest of the damaged frame and pulses a realign strobe.

Top module: `lcd_timing_gen`

Register addresses (wr_addr) and fields:
- 0: control. Bit 0 is run, bit 1 is sync-enable, bit 2 is recover-on-underflow, bit 3 is interrupt enable, bit 4 makes hsync active high, bit 5 makes vsync active high, bit 6 makes data-enable active high, bit 7 is the dot-clock falling-edge select.
- 1: line total. 2: hsync width. 3: horizontal wait. 4: active pixels per line.
- 5: frame total in lines. 6: vsync width in lines. 7: vertical wait. 8: active lines.
- 9: next buffer. 10: current buffer. 11: writing 1 to bit 0 clears frame-done.

## Requirements
- R1: A line lasts exactly line-total pixel clocks. The internal sync level of hsync is asserted during the first hsync-width clocks of each line.
- R2: A frame lasts exactly frame-total lines. The internal sync level of vsync is asserted during the first vsync-width lines of each frame.
- R3: Data-enable and pixel-valid are active in a line when the pixel count is at least h-wait and below h-wait plus active pixels. The line count must also be at least v-wait and below v-wait plus active lines.
- R4: Each of hsync, vsync and data-enable follows its own polarity bit (control bits 4, 5 and 6) as soon as that bit is written. After reset, hsync and vsync are active low and data-enable is active high.
- R5: While the sync-enable bit (control bit 1) is clear, hsync, vsync and data-enable stay at their inactive levels. Pixel-valid keeps running.
- R6: Scanning starts at pixel 0 of line 0 one clock after the run bit is seen set. After the run bit is cleared, scanning continues until fifo_empty is sampled high. run_status then drops on that clock edge.
- R7: cur_buf takes the value of the next-buffer register at each frame boundary. It can also be written directly at address 10.
- R8: frame_done is set at the end of each frame and cleared by a write of 1 to bit 0 at address 11. irq equals frame_done only while control bit 3 is set.
- R9: Timing counts written during a frame do not change the current frame. They apply from the next frame.
- R10: With control bit 2 set, an underflow holds pixel-valid low for the rest of the frame, and realign is high during the first clock of the next frame. With bit 2 clear, an underflow has no effect.
- R11: The pclk_fall output follows control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| fifo_empty | input | 1 | Pixel FIFO reports empty |
| underflow | input | 1 | Pixel FIFO underflow event |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| de | output | 1 | Data enable, programmable polarity |
| pix_valid | output | 1 | Active pixel strobe for the fetch side |
| frame_done | output | 1 | Frame-done status |
| irq | output | 1 | Frame-done interrupt |
| run_status | output | 1 | Scanning in progress |
| cur_buf | output | 32 | Current framebuffer base |
| realign | output | 1 | Fetch realign pulse after an underflow frame |
| pclk_fall | output | 1 | Panel samples on the falling dot-clock edge |

## Verification
The assertions assume the following about the inputs:
- While the block is running, timing counts are nonzero.
- fifo_empty is the only event that ends a stop. Nothing else forces run_status low.
- Underflow pulses arrive only while scanning.

The stimulus keeps within these assumptions:
- It programs every count before setting run.
- It changes counts during a run only to other nonzero values.
- It raises fifo_empty once, after the run bit has been cleared.
- It pulses underflow for one clock at a known position in the frame.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 12,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          fifo_empty,
  input  logic          underflow,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_valid,
  output logic          frame_done,
  output logic          irq,
  output logic          run_status,
  output logic [AW-1:0] cur_buf,
  output logic          realign,
  output logic          pclk_fall
);
  localparam logic [3:0] A_CTRL = 4'd0, A_HT = 4'd1, A_HSW = 4'd2, A_HWAIT = 4'd3,
                         A_HACT = 4'd4, A_VT = 4'd5, A_VSW = 4'd6, A_VWAIT = 4'd7,
                         A_VACT = 4'd8, A_NEXT = 4'd9, A_CUR = 4'd10, A_CLR = 4'd11;

  logic [7:0]    ctrl;
  logic [CW-1:0] r_ht, r_hsw, r_hwait, r_hact, r_vt, r_vsw, r_vwait, r_vact;
  logic [CW-1:0] sh_ht, sh_hsw, sh_hwait, sh_hact, sh_vt, sh_vsw, sh_vwait, sh_vact;
  logic [AW-1:0] next_buf;
  logic [CW-1:0] hcnt, vcnt;
  logic          running, uf_hold;

  wire run_bit  = ctrl[0];
  wire sync_en  = ctrl[1];
  wire recover  = ctrl[2];
  wire irq_en   = ctrl[3];

  wire [CW-1:0] ht_last = (sh_ht == '0) ? '0 : sh_ht - 1'b1;
  wire [CW-1:0] vt_last = (sh_vt == '0) ? '0 : sh_vt - 1'b1;
  wire line_end  = running && (hcnt >= ht_last);
  wire frame_end = line_end && (vcnt >= vt_last);

  wire [CW:0] h_stop = {1'b0, sh_hwait} + {1'b0, sh_hact};
  wire [CW:0] v_stop = {1'b0, sh_vwait} + {1'b0, sh_vact};
  wire h_act  = (hcnt >= sh_hwait) && ({1'b0, hcnt} < h_stop);
  wire v_act  = (vcnt >= sh_vwait) && ({1'b0, vcnt} < v_stop);
  wire active = running && h_act && v_act;

  wire hs_lvl = running && sync_en && (hcnt < sh_hsw);
  wire vs_lvl = running && sync_en && (vcnt < sh_vsw);
  wire de_lvl = sync_en && active;

  assign hsync      = ctrl[4] ? hs_lvl : ~hs_lvl;
  assign vsync      = ctrl[5] ? vs_lvl : ~vs_lvl;
  assign de         = ctrl[6] ? de_lvl : ~de_lvl;
  assign pix_valid  = active && !uf_hold;
  assign irq        = frame_done && irq_en;
  assign run_status = running;
  assign pclk_fall  = ctrl[7];

  wire wr_hit_clr = wr_en && (wr_addr == A_CLR) && wr_data[0];

  // programmed registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= 8'h40;
      r_ht    <= '0; r_hsw   <= '0; r_hwait <= '0; r_hact <= '0;
      r_vt    <= '0; r_vsw   <= '0; r_vwait <= '0; r_vact <= '0;
      next_buf <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl    <= wr_data[7:0];
        A_HT:    r_ht    <= wr_data[CW-1:0];
        A_HSW:   r_hsw   <= wr_data[CW-1:0];
        A_HWAIT: r_hwait <= wr_data[CW-1:0];
        A_HACT:  r_hact  <= wr_data[CW-1:0];
        A_VT:    r_vt    <= wr_data[CW-1:0];
        A_VSW:   r_vsw   <= wr_data[CW-1:0];
        A_VWAIT: r_vwait <= wr_data[CW-1:0];
        A_VACT:  r_vact  <= wr_data[CW-1:0];
        A_NEXT:  next_buf <= wr_data[AW-1:0];
        default: ;
      endcase
    end
  end

  // shadow copy: follows while idle, reloads at frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ht <= '0; sh_hsw <= '0; sh_hwait <= '0; sh_hact <= '0;
      sh_vt <= '0; sh_vsw <= '0; sh_vwait <= '0; sh_vact <= '0;
    end else if (!running || frame_end) begin
      sh_ht <= r_ht; sh_hsw <= r_hsw; sh_hwait <= r_hwait; sh_hact <= r_hact;
      sh_vt <= r_vt; sh_vsw <= r_vsw; sh_vwait <= r_vwait; sh_vact <= r_vact;
    end
  end

  // scan counters and run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!running) begin
      running <= run_bit;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (!run_bit && fifo_empty) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // frame status, buffers, underflow recovery
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      cur_buf    <= '0;
      uf_hold    <= 1'b0;
      realign    <= 1'b0;
    end else begin
      if (frame_end)       frame_done <= 1'b1;
      else if (wr_hit_clr) frame_done <= 1'b0;

      if (frame_end)                          cur_buf <= next_buf;
      else if (wr_en && (wr_addr == A_CUR))   cur_buf <= wr_data[AW-1:0];

      realign <= frame_end && uf_hold;
      if (frame_end || !running)              uf_hold <= 1'b0;
      else if (underflow && recover)          uf_hold <= 1'b1;
    end
  end

  p_hcnt_in_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sh_ht != '0) |-> (hcnt < sh_ht));
  p_vcnt_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sh_vt != '0) |-> (vcnt < sh_vt));
  p_stop_after_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(fifo_empty));
  p_buf_promote_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cur_buf == $past(next_buf)));
  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> $past(frame_end));
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frame_end) |=> ($stable(sh_ht) && $stable(sh_vt) && $stable(sh_hact)));
  p_realign_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> $past(uf_hold));
endmodule

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic fifo_empty = 0, underflow = 0;
  logic hsync, vsync, de, pix_valid, frame_done, irq, run_status, realign, pclk_fall;
  logic [31:0] cur_buf;

  int n_chk = 0, n_fail = 0;
  int b_ht = 20, b_hsw = 3, b_hw = 5, b_ha = 10;
  int b_vt = 6, b_vsw = 2, b_vw = 2, b_va = 3;
  bit b_sync = 1, b_hs_hi = 0, b_vs_hi = 0, b_de_hi = 1, b_uf = 0;

  lcd_timing_gen uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fifo_empty(fifo_empty), .underflow(underflow), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_valid(pix_valid), .frame_done(frame_done), .irq(irq),
    .run_status(run_status), .cur_buf(cur_buf), .realign(realign), .pclk_fall(pclk_fall));

  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = a[3:0]; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  // walks one frame from pixel h0 of line 0, ends at pixel 0 of line 0
  task automatic scan_frame(int h0, string req);
    int bad = 0;
    for (int v = 0; v < b_vt; v++) begin
      for (int h = (v == 0 ? h0 : 0); h < b_ht; h++) begin
        bit hl = b_sync && h < b_hsw;
        bit vl = b_sync && v < b_vsw;
        bit act = h >= b_hw && h < b_hw + b_ha && v >= b_vw && v < b_vw + b_va;
        bit dl = b_sync && act;
        bit ehs = b_hs_hi ? hl : !hl;
        bit evs = b_vs_hi ? vl : !vl;
        bit ede = b_de_hi ? dl : !dl;
        bit epv = act && !b_uf;
        if (hsync !== ehs || vsync !== evs || de !== ede || pix_valid !== epv || run_status !== 1) begin
          if (bad < 4)
            $display("FAIL %s at h=%0d v=%0d: actual hs%0d vs%0d de%0d pv%0d expected hs%0d vs%0d de%0d pv%0d",
                     req, h, v, hsync, vsync, de, pix_valid, ehs, evs, ede, epv);
          bad++;
        end
        @(negedge clk);
      end
    end
    n_chk++;
    if (bad != 0) n_fail++;
  endtask

  task automatic t_reset;
    chk(run_status == 0, "R6", "run after reset", run_status, 0);
    chk(hsync == 1 && vsync == 1, "R4", "sync idle low-active", {hsync, vsync}, 3);
    chk(de == 0, "R4", "de idle high-active", de, 0);
    chk(cur_buf == 0 && irq == 0 && pclk_fall == 0, "R7", "reset buf/irq", cur_buf, 0);
  endtask

  task automatic t_start;
    wr(1, b_ht); wr(2, b_hsw); wr(3, b_hw); wr(4, b_ha);
    wr(5, b_vt); wr(6, b_vsw); wr(7, b_vw); wr(8, b_va);
    wr(10, 32'h100);
    chk(cur_buf == 32'h100, "R7", "direct cur write", cur_buf, 32'h100);
    wr(9, 32'h200);
    wr(0, 32'h4B);
    chk(run_status == 0, "R6", "run not yet", run_status, 0);
    @(negedge clk);
    chk(run_status == 1, "R6", "run started", run_status, 1);
    scan_frame(0, "R1 R2 R3");
    chk(cur_buf == 32'h200, "R7", "buffer promoted", cur_buf, 32'h200);
    chk(irq == 1 && frame_done == 1, "R8", "frame done irq", irq, 1);
  endtask

  task automatic t_irq;
    wr(11, 1);
    chk(frame_done == 0 && irq == 0, "R8", "done cleared", frame_done, 0);
    scan_frame(1, "R1");
    chk(irq == 1, "R8", "done set again", irq, 1);
    wr(0, 32'h43);
    wr(11, 1);
    scan_frame(2, "R3");
    chk(frame_done == 1 && irq == 0, "R8", "irq masked", irq, 0);
  endtask

  task automatic t_polarity;
    wr(0, 32'h33);
    b_hs_hi = 1; b_vs_hi = 1; b_de_hi = 0;
    scan_frame(1, "R4");
    wr(0, 32'h41);
    b_hs_hi = 0; b_vs_hi = 0; b_de_hi = 1; b_sync = 0;
    scan_frame(1, "R5");
    wr(0, 32'h43);
    b_sync = 1;
    scan_frame(1, "R5");
  endtask

  task automatic t_shadow;
    wr(1, 24);
    scan_frame(1, "R9");
    b_ht = 24;
    scan_frame(0, "R9");
  endtask

  task automatic t_underflow;
    wr(0, 32'h47);
    scan_frame(1, "R10");
    underflow = 1; @(negedge clk); underflow = 0;
    b_uf = 1;
    scan_frame(1, "R10");
    b_uf = 0;
    chk(realign == 1, "R10", "realign pulse", realign, 1);
    scan_frame(0, "R10");
    wr(0, 32'h43);
    scan_frame(1, "R10");
    underflow = 1; @(negedge clk); underflow = 0;
    scan_frame(1, "R10");
    chk(realign == 0, "R10", "no realign without recover", realign, 0);
  endtask

  task automatic t_stop;
    wr(0, 32'hC3);
    chk(pclk_fall == 1, "R11", "clock edge select", pclk_fall, 1);
    wr(0, 32'h42);
    repeat (40) @(negedge clk);
    chk(run_status == 1, "R6", "draining", run_status, 1);
    fifo_empty = 1;
    @(negedge clk);
    chk(run_status == 0, "R6", "stopped on empty", run_status, 0);
    chk(de == 0 && hsync == 1, "R6", "outputs idle after stop", {de, hsync}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_start;
    t_irq;
    t_polarity;
    t_shadow;
    t_underflow;
    t_stop;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule